// File: doc/BRIEF.md
# Multi-Source Chip Reset Sequencer

This block turns four reset sources into separate reset outputs, one for each domain of the chip. The sources are a power-good indication, an active-low board reset pin, a one-cycle partial-reset request and a one-cycle full soft-reset request. The outputs are an active-low core reset, an active-low USB-domain reset, a one-cycle request to load configuration from external nonvolatile memory, a one-cycle request to power down the Ethernet PHY, a ready flag that software can read, and the self-clearing partial-reset request bit.

The two hardware sources, power-up and the pin, reach every domain and clear the ready flag. A power-up hold runs for a counted interval, `POR_CYCLES`, which stands for roughly 22 ms of core clock. The soft reset reaches the core and USB domains but leaves ready set. The partial reset reaches only the core. It spares the USB controller and PHY domain and never triggers a configuration reload. Each output reset is asserted asynchronously and released through a `SYNC_STAGES`-deep synchroniser. The one-cycle requests travel through a matching delay, so they appear in the same cycle that ready rises.

When sources overlap, the source with the wider reach wins. A hardware reset overrides soft and partial resets. A soft reset overrides a partial reset that is already in progress.

Top module: `chip_reset_ctrl`

## Requirements
- R1: While `pwrOnN` is low, `coreRstN`, `usbRstN` and `ready` are 0. After `pwrOnN` rises, all three stay 0 for POR_CYCLES+3 rising clock edges and go to 1 together at the next edge.
- R2: When a power-up hold completes, `cfgLoad` and `phyPwrDn` are each 1 for exactly one cycle, in the same cycle that `ready` becomes 1.
- R3: `rstPinN` low drives `coreRstN`, `usbRstN` and `ready` to 0 from the first clock edge after it falls. They stay 0 until PULSE_CYCLES+3 edges after the pin rises. On completion, `phyPwrDn` pulses for one cycle and `cfgLoad` stays 0, unless R4 applies.
- R4: A pin reset that starts before a power-up hold has completed still produces the one `cfgLoad` pulse when the combined hardware reset ends.
- R5: A one-cycle `softReq` sampled while idle holds `coreRstN` and `usbRstN` at 0 for PULSE_CYCLES+2 cycles, starting just after the sampling edge. `ready` stays 1 and neither request pulse fires.
- R6: A one-cycle `liteReq` sampled while idle holds only `coreRstN` at 0 for PULSE_CYCLES+2 cycles. `usbRstN` and `ready` stay 1 and neither request pulse fires.
- R7: `liteBit` becomes 1 at the edge that samples `liteReq`, clears itself when the partial-reset pulse ends, and is 0 once `coreRstN` is back at 1.
- R8: A `softReq` during a partial reset turns it into a soft reset. `usbRstN` is 0 for PULSE_CYCLES+2 cycles from that request, and `coreRstN` stays 0 until the same point.
- R9: A `liteReq` during a soft reset is ignored. When both requests arrive in the same cycle, the soft reset wins.
- R10: `softReq` and `liteReq` have no effect while a hardware reset is in progress. The reset lengths in R3 are unchanged.
- R11: Each output reset is released only after its internal hold has been inactive for at least two rising clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| pwrOnN | input | 1 | Power-good indication, 0 while supply is not yet valid |
| rstPinN | input | 1 | Board reset pin, active low, asynchronous |
| liteReq | input | 1 | One-cycle request for a core-only partial reset |
| softReq | input | 1 | One-cycle request for a core and USB soft reset |
| coreRstN | output | 1 | Core domain reset, active low |
| usbRstN | output | 1 | USB controller domain reset, active low |
| cfgLoad | output | 1 | One-cycle request to reload configuration memory |
| phyPwrDn | output | 1 | One-cycle request to put the Ethernet PHY in power-down |
| ready | output | 1 | Readable flag, 1 once hardware reset is complete |
| liteBit | output | 1 | Self-clearing partial-reset request bit |

## Verification
The bench builds the block with POR_CYCLES=20, PULSE_CYCLES=6 and SYNC_STAGES=2. A power-up hold that short lets the bench start a pin reset inside it, which exercises the pending reload of R4, and it leaves room to repeat the power-up in the middle of the run. A six-cycle pulse is long enough to inject a second request in the middle of a soft or partial reset, so the escalation and the ignored cases of R8 to R10 are observed as exact low-cycle counts on each output.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

  typedef enum logic [2:0] {
    ST_HOLD_POR = 3'd0,
    ST_HOLD_PIN = 3'd1,
    ST_SOFT     = 3'd2,
    ST_LITE     = 3'd3,
    ST_RUN      = 3'd4
  } rstState_e;

  // Strobes from the sequencing control to the datapath
  typedef struct packed {
    logic hwHold;      // hardware reset in progress (gates ready)
    logic coreHold;    // core domain held
    logic usbHold;     // USB domain held
    logic cntClr;      // restart the interval counter
    logic cntEn;       // advance the interval counter
    logic longLimit;   // compare against the power-up interval
    logic cfgLoadStb;  // configuration reload at hardware completion
    logic phyDownStb;  // PHY power-down at hardware completion
  } rstStrb_t;

endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr,
  output logic q
);
  logic [STAGES-1:0] shiftQ;

  always_ff @(posedge clk or posedge clr) begin
    if (clr) shiftQ <= '0;
    else     shiftQ <= {shiftQ[STAGES-2:0], 1'b1};
  end

  assign q = shiftQ[STAGES-1];
endmodule

// File: rtl/rstc_datapath.sv
module rstc_datapath
  import rstc_pkg::*;
#(
  parameter int POR_CYCLES   = 1320000,
  parameter int PULSE_CYCLES = 16,
  parameter int SYNC_STAGES  = 2
) (
  input  logic     clk,
  input  logic     pwrOnN,
  input  logic     rstPinN,
  input  rstStrb_t strb,
  output logic     porSyncN,
  output logic     pinSyncN,
  output logic     cntAtLimit,
  output logic     coreRstN,
  output logic     usbRstN,
  output logic     ready,
  output logic     cfgLoad,
  output logic     phyPwrDn
);
  localparam int MAX_CYC = (POR_CYCLES > PULSE_CYCLES) ? POR_CYCLES : PULSE_CYCLES;
  localparam int CW      = $clog2(MAX_CYC + 1);
  localparam int DLY     = SYNC_STAGES + 1;
  localparam logic [CW-1:0] POR_LAST   = CW'(POR_CYCLES - 1);
  localparam logic [CW-1:0] PULSE_LAST = CW'(PULSE_CYCLES - 1);
  localparam int N_DOM = 3;

  // Input synchronisers: asynchronous assertion, clocked release
  rstc_sync #(.STAGES(SYNC_STAGES)) uPorSync (.clk(clk), .clr(!pwrOnN),  .q(porSyncN));
  rstc_sync #(.STAGES(SYNC_STAGES)) uPinSync (.clk(clk), .clr(!rstPinN), .q(pinSyncN));

  // Per-domain release synchronisers
  logic [N_DOM-1:0] holdVec;
  logic [N_DOM-1:0] releaseVec;
  assign holdVec = {strb.usbHold, strb.coreHold, strb.hwHold};

  for (genvar g = 0; g < N_DOM; g++) begin : gRelease
    rstc_sync #(.STAGES(SYNC_STAGES)) uRel (
      .clk(clk), .clr(holdVec[g]), .q(releaseVec[g])
    );
  end

  assign ready    = releaseVec[0];
  assign coreRstN = releaseVec[1];
  assign usbRstN  = releaseVec[2];

  // Shared interval counter
  logic [CW-1:0] cnt;
  always_ff @(posedge clk or negedge porSyncN) begin
    if (!porSyncN)        cnt <= '0;
    else if (strb.cntClr) cnt <= '0;
    else if (strb.cntEn)  cnt <= cnt + 1'b1;
  end
  assign cntAtLimit = strb.longLimit ? (cnt == POR_LAST) : (cnt == PULSE_LAST);

  // Completion requests delayed to line up with the ready release
  logic [DLY-1:0] cfgPipe;
  logic [DLY-1:0] phyPipe;
  always_ff @(posedge clk or negedge porSyncN) begin
    if (!porSyncN) begin
      cfgPipe <= '0;
      phyPipe <= '0;
    end else begin
      cfgPipe <= {cfgPipe[DLY-2:0], strb.cfgLoadStb};
      phyPipe <= {phyPipe[DLY-2:0], strb.phyDownStb};
    end
  end
  assign cfgLoad  = cfgPipe[DLY-1];
  assign phyPwrDn = phyPipe[DLY-1];
endmodule

// File: rtl/rstc_control.sv
module rstc_control
  import rstc_pkg::*;
(
  input  logic     clk,
  input  logic     porSyncN,
  input  logic     pinSyncN,
  input  logic     softReq,
  input  logic     liteReq,
  input  logic     cntAtLimit,
  output rstStrb_t strb,
  output logic     liteBit
);
  rstState_e state, stateNext;
  logic      cfgLoaded, cfgLoadedNext, liteNext;

  always_comb begin
    stateNext     = state;
    liteNext      = liteBit;
    cfgLoadedNext = cfgLoaded;
    strb          = '0;
    strb.hwHold    = (state == ST_HOLD_POR) || (state == ST_HOLD_PIN);
    strb.coreHold  = (state != ST_RUN);
    strb.usbHold   = (state == ST_HOLD_POR) || (state == ST_HOLD_PIN) || (state == ST_SOFT);
    strb.longLimit = (state == ST_HOLD_POR);

    if (!pinSyncN) begin
      // pin reset outranks every other source except power-up
      stateNext   = ST_HOLD_PIN;
      strb.cntClr = 1'b1;
      liteNext    = 1'b0;
    end else begin
      unique case (state)
        ST_HOLD_POR, ST_HOLD_PIN: begin
          if (cntAtLimit) begin
            stateNext       = ST_RUN;
            strb.phyDownStb = 1'b1;
            strb.cfgLoadStb = !cfgLoaded;
            cfgLoadedNext   = 1'b1;
          end else begin
            strb.cntEn = 1'b1;
          end
        end
        ST_SOFT: begin
          if (cntAtLimit) stateNext  = ST_RUN;
          else            strb.cntEn = 1'b1;
        end
        ST_LITE: begin
          if (softReq) begin
            stateNext   = ST_SOFT;
            strb.cntClr = 1'b1;
            liteNext    = 1'b0;
          end else if (cntAtLimit) begin
            stateNext = ST_RUN;
            liteNext  = 1'b0;
          end else begin
            strb.cntEn = 1'b1;
          end
        end
        ST_RUN: begin
          if (softReq) begin
            stateNext   = ST_SOFT;
            strb.cntClr = 1'b1;
          end else if (liteReq) begin
            stateNext   = ST_LITE;
            strb.cntClr = 1'b1;
            liteNext    = 1'b1;
          end
        end
        default: begin
          stateNext   = ST_HOLD_POR;
          strb.cntClr = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge porSyncN) begin
    if (!porSyncN) begin
      state     <= ST_HOLD_POR;
      liteBit   <= 1'b0;
      cfgLoaded <= 1'b0;
    end else begin
      state     <= stateNext;
      liteBit   <= liteNext;
      cfgLoaded <= cfgLoadedNext;
    end
  end
endmodule

// File: rtl/chip_reset_ctrl.sv
module chip_reset_ctrl
  import rstc_pkg::*;
#(
  parameter int POR_CYCLES   = 1320000,
  parameter int PULSE_CYCLES = 16,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic pwrOnN,
  input  logic rstPinN,
  input  logic liteReq,
  input  logic softReq,
  output logic coreRstN,
  output logic usbRstN,
  output logic cfgLoad,
  output logic phyPwrDn,
  output logic ready,
  output logic liteBit
);
  rstStrb_t strb;
  logic     porSyncN, pinSyncN, cntAtLimit;
  logic     coreHoldTap;

  rstc_control uCtl (
    .clk(clk), .porSyncN(porSyncN), .pinSyncN(pinSyncN),
    .softReq(softReq), .liteReq(liteReq), .cntAtLimit(cntAtLimit),
    .strb(strb), .liteBit(liteBit)
  );

  rstc_datapath #(
    .POR_CYCLES(POR_CYCLES), .PULSE_CYCLES(PULSE_CYCLES), .SYNC_STAGES(SYNC_STAGES)
  ) uDp (
    .clk(clk), .pwrOnN(pwrOnN), .rstPinN(rstPinN), .strb(strb),
    .porSyncN(porSyncN), .pinSyncN(pinSyncN), .cntAtLimit(cntAtLimit),
    .coreRstN(coreRstN), .usbRstN(usbRstN), .ready(ready),
    .cfgLoad(cfgLoad), .phyPwrDn(phyPwrDn)
  );

  assign coreHoldTap = strb.coreHold;
endmodule

// File: rtl/rstc_checker.sv
module rstc_checker (
  input logic clk,
  input logic pwrOnN,
  input logic coreRstN,
  input logic usbRstN,
  input logic ready,
  input logic cfgLoad,
  input logic phyPwrDn,
  input logic liteBit,
  input logic coreHold
);
  AST_NOT_READY_HOLDS_CORE: assert property (@(posedge clk) disable iff (!pwrOnN)
    !ready |-> !coreRstN);                                                      // R1
  AST_CFG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!pwrOnN)
    cfgLoad |=> !cfgLoad);                                                      // R2
  AST_CFG_WITH_READY: assert property (@(posedge clk) disable iff (!pwrOnN)
    cfgLoad |-> $rose(ready));                                                  // R2
  AST_PHY_WITH_READY: assert property (@(posedge clk) disable iff (!pwrOnN)
    phyPwrDn |-> $rose(ready));                                                 // R3
  AST_USB_NEEDS_CORE: assert property (@(posedge clk) disable iff (!pwrOnN)
    !usbRstN |-> !coreRstN);                                                    // R6
  AST_LITE_BIT_IN_RESET: assert property (@(posedge clk) disable iff (!pwrOnN)
    liteBit |-> !coreRstN);                                                     // R7
  AST_SYNC_RELEASE: assert property (@(posedge clk) disable iff (!pwrOnN)
    $rose(coreRstN) |-> ($past(!coreHold, 1) && $past(!coreHold, 2)));        // R11
endmodule

bind chip_reset_ctrl rstc_checker uChk (
  .clk(clk), .pwrOnN(pwrOnN), .coreRstN(coreRstN), .usbRstN(usbRstN),
  .ready(ready), .cfgLoad(cfgLoad), .phyPwrDn(phyPwrDn), .liteBit(liteBit),
  .coreHold(coreHoldTap)
);

// File: tb/tb_chip_reset_ctrl.sv
module tb_chip_reset_ctrl;
  localparam int POR_C = 20;
  localparam int PUL_C = 6;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic pwrOnN = 1'b1, rstPinN = 1'b1, liteReq = 1'b0, softReq = 1'b0;
  logic coreRstN, usbRstN, cfgLoad, phyPwrDn, ready, liteBit;

  chip_reset_ctrl #(.POR_CYCLES(POR_C), .PULSE_CYCLES(PUL_C), .SYNC_STAGES(2)) dut (
    .clk(clk), .pwrOnN(pwrOnN), .rstPinN(rstPinN), .liteReq(liteReq), .softReq(softReq),
    .coreRstN(coreRstN), .usbRstN(usbRstN), .cfgLoad(cfgLoad), .phyPwrDn(phyPwrDn),
    .ready(ready), .liteBit(liteBit)
  );

  typedef struct {
    string tag;
    int    core;
    int    usb;
    int    rdy;
    int    cfg;
    int    phy;
  } exp_t;

  exp_t expQ[$];
  int   nChk = 0, nBad = 0;
  bit   armed = 0, inEp = 0, done = 0;
  int   cCore = 0, cUsb = 0, cRdy = 0, cCfg = 0, cPhy = 0;

  task automatic chk(string tag, int act, int expv);
    nChk++;
    if (act != expv) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  endtask

  // Monitor: accumulate one reset episode, compare when core is released
  always @(negedge clk) begin
    if (armed) begin
      if (!coreRstN) inEp = 1;
      if (!coreRstN) cCore++;
      if (!usbRstN)  cUsb++;
      if (!ready)    cRdy++;
      cCfg += int'(cfgLoad);
      cPhy += int'(phyPwrDn);
      if (inEp && coreRstN) begin
        if (expQ.size() == 0) begin
          chk("R1 unexpected reset episode", 1, 0);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          chk({e.tag, " coreLowCycles"}, cCore, e.core);
          chk({e.tag, " usbLowCycles"},  cUsb,  e.usb);
          chk({e.tag, " readyLowCycles"}, cRdy, e.rdy);
          chk({e.tag, " cfgLoadPulses"}, cCfg,  e.cfg);
          chk({e.tag, " phyPwrDnPulses"}, cPhy, e.phy);
        end
        inEp = 0;
        cCore = 0; cUsb = 0; cRdy = 0; cCfg = 0; cPhy = 0;
      end
    end
  end

  task automatic push(string tag, int core, int usb, int rdy, int cfg, int phy);
    exp_t e;
    e.tag = tag; e.core = core; e.usb = usb; e.rdy = rdy; e.cfg = cfg; e.phy = phy;
    expQ.push_back(e);
  endtask

  task automatic waitIdle();
    while (expQ.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic doPor(int h);
    @(negedge clk); #1;
    push("R1 R2 power-up", h + POR_C + 3, h + POR_C + 3, h + POR_C + 3, 1, 1);
    pwrOnN = 1'b0;
    armed  = 1;
    repeat (h) @(negedge clk);
    #1 pwrOnN = 1'b1;
  endtask

  task automatic doPin(string tag, int l, bit softMid, bit liteMid);
    @(negedge clk); #1;
    push(tag, l + PUL_C + 3, l + PUL_C + 3, l + PUL_C + 3, 0, 1);
    rstPinN = 1'b0;
    repeat (2) @(negedge clk);
    #1 softReq = softMid; liteReq = liteMid;
    @(negedge clk); #1 softReq = 1'b0; liteReq = 1'b0;
    repeat (l - 3) @(negedge clk);
    #1 rstPinN = 1'b1;
  endtask

  task automatic pulseSoft();
    softReq = 1'b1;
    @(negedge clk); #1 softReq = 1'b0;
  endtask

  initial begin
    #1 pwrOnN = 1'b0;
    #2;
    chk("R1 reset state coreRstN", int'(coreRstN), 0);
    chk("R1 reset state usbRstN",  int'(usbRstN),  0);
    chk("R1 reset state ready",    int'(ready),    0);
    chk("R7 reset state liteBit",  int'(liteBit),  0);

    doPor(3);
    waitIdle();
    chk("R1 ready after power-up", int'(ready), 1);

    // R5 R11 soft reset alone
    @(negedge clk); #1;
    push("R5 R11 soft", PUL_C + 2, PUL_C + 2, 0, 0, 0);
    pulseSoft();
    waitIdle();

    // R6 R7 partial reset alone
    @(negedge clk); #1;
    push("R6 lite", PUL_C + 2, 0, 0, 0, 0);
    liteReq = 1'b1;
    @(negedge clk);
    chk("R7 liteBit set", int'(liteBit), 1);
    #1 liteReq = 1'b0;
    waitIdle();
    chk("R7 liteBit self-cleared", int'(liteBit), 0);

    // R3 pin reset while running
    doPin("R3 pin", 5, 1'b0, 1'b0);
    waitIdle();

    // R8 soft escalates a partial reset after 3 cycles
    @(negedge clk); #1;
    push("R8 lite then soft", 3 + PUL_C + 2, PUL_C + 2, 0, 0, 0);
    liteReq = 1'b1;
    @(negedge clk); #1 liteReq = 1'b0;
    repeat (2) @(negedge clk);
    #1 pulseSoft();
    waitIdle();
    chk("R8 liteBit cleared by escalation", int'(liteBit), 0);

    // R9 partial request during soft reset is ignored
    @(negedge clk); #1;
    push("R9 soft then lite", PUL_C + 2, PUL_C + 2, 0, 0, 0);
    pulseSoft();
    @(negedge clk); #1 liteReq = 1'b1;
    @(negedge clk); #1 liteReq = 1'b0;
    waitIdle();
    chk("R9 liteBit stays clear", int'(liteBit), 0);

    // R9 both requests in the same cycle: soft wins
    @(negedge clk); #1;
    push("R9 simultaneous", PUL_C + 2, PUL_C + 2, 0, 0, 0);
    softReq = 1'b1; liteReq = 1'b1;
    @(negedge clk); #1 softReq = 1'b0; liteReq = 1'b0;
    waitIdle();

    // R10 soft and partial requests during a pin reset
    doPin("R10 pin with soft", 6, 1'b1, 1'b0);
    waitIdle();
    doPin("R10 pin with lite", 6, 1'b0, 1'b1);
    waitIdle();
    chk("R10 liteBit clear after pin", int'(liteBit), 0);

    // R4 pin reset inside a power-up hold keeps the pending reload
    @(negedge clk); #1;
    push("R4 power-up then pin", 2 + 3 + 4 + PUL_C + 3, 2 + 3 + 4 + PUL_C + 3,
         2 + 3 + 4 + PUL_C + 3, 1, 1);
    pwrOnN = 1'b0;
    repeat (2) @(negedge clk);
    #1 pwrOnN = 1'b1;
    repeat (3) @(negedge clk);
    #1 rstPinN = 1'b0;
    repeat (4) @(negedge clk);
    #1 rstPinN = 1'b1;
    waitIdle();

    // R2 a second power-up mid-run reloads again
    doPor(5);
    waitIdle();

    // R6 partial reset after a hardware reset still spares USB
    @(negedge clk); #1;
    push("R6 lite after power-up", PUL_C + 2, 0, 0, 0, 0);
    liteReq = 1'b1;
    @(negedge clk); #1 liteReq = 1'b0;
    waitIdle();

    finishRun();
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk("R1 watchdog expired", 1, 0);
    finishRun();
  end
endmodule